// File: doc/BRIEF.md
# Integer Compare-and-Branch Condition Unit

This block decides whether a fused integer branch is taken. It receives two 64-bit operands, a size code that picks an 8-, 16-, 32- or 64-bit view of them, and a 6-bit opcode. It returns the arithmetic result of the fused operation, a taken flag and a flag for an illegal opcode. The fused operations are subtract, add, signed and unsigned compare, AND/OR/XOR tested against zero, single-bit test, all-bits and any-bits mask tests, and increment-then-compare. Target address arithmetic belongs to the surrounding pipeline.

The evaluation is combinational and ends in one output register. A valid input produces a valid output one cycle later. The output register keeps its contents while no new operation arrives.

Opcode layout: bits [5:4] select the group, bits [3:1] select the condition within the group, and bit 0 inverts the condition. Group 0 is subtract, group 1 is add, group 2 is compare, and group 3 holds the miscellaneous operations. Size code 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64.

Top module: `cmpbr_unit`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid` is high after that edge and the outputs show the result for that operation. When `in_valid` is low, `out_valid` goes low and `out_result`, `out_taken` and `out_wrong` keep their previous values.
- R2: Both operands are masked to the selected size. The sign bit is the top bit of that size. `out_result` is zero-extended from that size.
- R3: In the compare group (bits [5:4]=2) the condition is selected by bits [3:1]: 0 is equal, 1 is signed below, 2 is signed above, 3 is unsigned below, 4 is unsigned above. The result of a compare is 0.
- R4: For any legal opcode, `out_taken` equals the selected condition XOR opcode bit 0.
- R5: In the subtract group (0), the result is a-b. Sub-codes: 0 zero, 1 negative, 2 positive (sign bit clear and result nonzero), 3 signed overflow (sign bit of (a^b)&(a^r)), 4 borrow (masked r greater than masked a).
- R6: In the add group (1), the result is a+b. The sub-codes are the same as R5, except that code 3 is the sign bit of ~(a^b)&(a^r) and code 4 is carry (masked r less than masked a). Overflow never sets `out_wrong`.
- R7: In group 3, codes 0, 1 and 2 produce a&b, a|b and a^b respectively. The condition is that the masked result is zero.
- R8: Group 3 code 3 tests bit number b of a. The result is 0. An index equal to or larger than the operand width reads as 0.
- R9: Group 3 code 4 is true when (a&b)==b. Code 5 is true when (a&b)!=0. Both produce result 0.
- R10: Group 3 codes 6 and 7 produce a+1 and compare it signed against b. Code 6 is true when the result is below b, code 7 when it is above b.
- R11: Sub-codes 5 to 7 in groups 0, 1 and 2 set `out_wrong`. In that case `out_taken` and `out_result` are 0, whatever opcode bit 0 is.
- R12: After reset, `out_valid`, `out_taken`, `out_wrong` and `out_result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand, mask or bit index |
| size | input | 2 | Operand size code |
| opcode | input | 6 | Group, condition and invert bit |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 64 | Zero-extended result |
| out_taken | output | 1 | Branch taken |
| out_wrong | output | 1 | Illegal opcode |

## Verification
On every cycle the assertions check the following:
- The one-cycle valid latency.
- That the outputs hold when no operation arrives.
- That an illegal opcode always gives a zero result and not-taken.
- That illegal compare codes are flagged.
- That results are zero-extended for byte operations.
- That compares and tests leave a zero result.

Only the bench scenarios can show that each condition is correct. This covers signed versus unsigned ordering at the size boundaries, overflow and carry at each width, out-of-range bit indices and inversion. The bench shows this by comparing every output against a behavioural model that uses sign extension.

// File: rtl/cmpbr_unit.sv
module cmpbr_unit #(
  parameter int DW  = 64,
  parameter int OPW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [DW-1:0]  op_a,
  input  logic [DW-1:0]  op_b,
  input  logic [1:0]     size,
  input  logic [OPW-1:0] opcode,
  output logic           out_valid,
  output logic [DW-1:0]  out_result,
  output logic           out_taken,
  output logic           out_wrong
);
  localparam logic [1:0] G_SUB = 2'd0, G_ADD = 2'd1, G_CMP = 2'd2, G_MISC = 2'd3;

  logic [DW-1:0] mask, sbit, am, bm;
  logic [DW-1:0] r_sub, r_add, r_inc, r_and, r_or, r_xor;
  logic [7:0]    width;
  logic [1:0]    grp;
  logic [2:0]    sel;
  logic          inv;

  assign grp = opcode[5:4];
  assign sel = opcode[3:1];
  assign inv = opcode[0];

  always_comb begin
    case (size)
      2'd0:    mask = DW'(8'hFF);
      2'd1:    mask = DW'(16'hFFFF);
      2'd2:    mask = DW'(32'hFFFF_FFFF);
      default: mask = '1;
    endcase
  end

  assign width = 8'd8 << size;
  assign sbit  = (mask >> 1) + DW'(1);
  assign am    = op_a & mask;
  assign bm    = op_b & mask;

  assign r_sub = (op_a - op_b) & mask;
  assign r_add = (op_a + op_b) & mask;
  assign r_inc = (op_a + DW'(1)) & mask;
  assign r_and = am & bm;
  assign r_or  = am | bm;
  assign r_xor = am ^ bm;

  logic sub_ovf, add_ovf, borrow, carry;
  assign sub_ovf = |(((op_a ^ op_b) & (op_a ^ r_sub)) & sbit);
  assign add_ovf = |((~(op_a ^ op_b) & (op_a ^ r_add)) & sbit);
  assign borrow  = r_sub > am;
  assign carry   = r_add < am;

  logic [DW-1:0] fa, fb, fi;
  assign fa = am ^ sbit;
  assign fb = bm ^ sbit;
  assign fi = r_inc ^ sbit;

  logic bit_sel;
  assign bit_sel = (bm < DW'(width)) ? am[bm[$clog2(DW)-1:0]] : 1'b0;

  function automatic logic arith_cond(input logic [2:0] c, input logic [DW-1:0] r,
                                      input logic [DW-1:0] sb, input logic ovf,
                                      input logic cy);
    case (c)
      3'd0:    return r == '0;
      3'd1:    return |(r & sb);
      3'd2:    return ~|(r & sb) && (r != '0);
      3'd3:    return ovf;
      default: return cy;
    endcase
  endfunction

  logic          cond, wrong;
  logic [DW-1:0] res;

  always_comb begin
    cond  = 1'b0;
    wrong = 1'b0;
    res   = '0;
    case (grp)
      G_SUB: begin
        res   = r_sub;
        wrong = sel > 3'd4;
        cond  = arith_cond(sel, r_sub, sbit, sub_ovf, borrow);
      end
      G_ADD: begin
        res   = r_add;
        wrong = sel > 3'd4;
        cond  = arith_cond(sel, r_add, sbit, add_ovf, carry);
      end
      G_CMP: begin
        case (sel)
          3'd0:    cond = am == bm;
          3'd1:    cond = fa < fb;
          3'd2:    cond = fa > fb;
          3'd3:    cond = am < bm;
          3'd4:    cond = am > bm;
          default: wrong = 1'b1;
        endcase
      end
      default: begin
        case (sel)
          3'd0: begin res = r_and; cond = r_and == '0; end
          3'd1: begin res = r_or;  cond = r_or  == '0; end
          3'd2: begin res = r_xor; cond = r_xor == '0; end
          3'd3: cond = bit_sel;
          3'd4: cond = (am & bm) == bm;
          3'd5: cond = (am & bm) != '0;
          3'd6: begin res = r_inc; cond = fi < fb; end
          default: begin res = r_inc; cond = fi > fb; end
        endcase
      end
    endcase
    if (wrong) res = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_taken  <= 1'b0;
      out_wrong  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= res;
        out_wrong  <= wrong;
        out_taken  <= wrong ? 1'b0 : (cond ^ inv);
      end
    end
  end
endmodule

// File: rtl/cmpbr_unit_chk.sv
module cmpbr_unit_chk #(
  parameter int DW  = 64,
  parameter int OPW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [DW-1:0]  op_a,
  input logic [DW-1:0]  op_b,
  input logic [1:0]     size,
  input logic [OPW-1:0] opcode,
  input logic           out_valid,
  input logic [DW-1:0]  out_result,
  input logic           out_taken,
  input logic           out_wrong
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_taken) && $stable(out_wrong)));
  a_r11_wrong_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_wrong |-> (!out_taken && out_result == '0));
  a_r11_cmp_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[5:4] == 2'd2 && opcode[3:1] > 3'd4) |=> out_wrong);
  a_r2_byte_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd0) |=> (out_result[DW-1:8] == '0));
  a_r3_cmp_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[5:4] == 2'd2) |=> (out_result == '0));
  a_r9_test_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[5:4] == 2'd3 && opcode[3:1] inside {3'd3, 3'd4, 3'd5}) |=> (out_result == '0 && !out_wrong));
endmodule

bind cmpbr_unit cmpbr_unit_chk #(.DW(DW), .OPW(OPW)) u_chk (.*);

// File: tb/sim_cmpbr_unit.sv
module sim_cmpbr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  size = '0;
  logic [5:0]  opcode = '0;
  logic        out_valid, out_taken, out_wrong;
  logic [63:0] out_result;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  cmpbr_unit u0 (.*);

  function automatic longint sx(input logic [63:0] v, input int w);
    logic [63:0] t;
    t = v;
    for (int i = w; i < 64; i++) t[i] = v[w-1];
    return longint'(t);
  endfunction

  task automatic model(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                       input logic [5:0] op, output logic [63:0] er, output logic et,
                       output logic ew, output string tag);
    int w;
    logic [63:0] m, s, am, bm, r;
    logic c;
    longint sa, sbv;
    w = 8 << sz;
    m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    s = 64'd1 << (w - 1);
    am = a & m; bm = b & m;
    sa = sx(am, w); sbv = sx(bm, w);
    c = 1'b0; ew = 1'b0; er = '0; tag = "R4";
    case (op[5:4])
      2'd0, 2'd1: begin
        tag = (op[5:4] == 2'd0) ? "R5" : "R6";
        if (op[5:4] == 2'd0) r = (a - b) & m; else r = (a + b) & m;
        er = r;
        case (op[3:1])
          3'd0: c = (r == 0);
          3'd1: c = (r & s) != 0;
          3'd2: c = ((r & s) == 0) && (r != 0);
          3'd3: c = (op[5:4] == 2'd0) ? (((a ^ b) & (a ^ r) & s) != 0)
                                      : ((~(a ^ b) & (a ^ r) & s) != 0);
          3'd4: c = (op[5:4] == 2'd0) ? (r > am) : (r < am);
          default: begin ew = 1'b1; tag = "R11"; end
        endcase
      end
      2'd2: begin
        tag = "R3";
        case (op[3:1])
          3'd0: c = am == bm;
          3'd1: c = sa < sbv;
          3'd2: c = sa > sbv;
          3'd3: c = am < bm;
          3'd4: c = am > bm;
          default: begin ew = 1'b1; tag = "R11"; end
        endcase
      end
      default: begin
        case (op[3:1])
          3'd0: begin tag = "R7"; er = am & bm; c = er == 0; end
          3'd1: begin tag = "R7"; er = am | bm; c = er == 0; end
          3'd2: begin tag = "R7"; er = am ^ bm; c = er == 0; end
          3'd3: begin tag = "R8"; c = (bm < 64'(w)) ? am[bm[5:0]] : 1'b0; end
          3'd4: begin tag = "R9"; c = (am & bm) == bm; end
          3'd5: begin tag = "R9"; c = (am & bm) != 0; end
          default: begin
            tag = "R10";
            er = (a + 64'd1) & m;
            if (op[3:1] == 3'd6) c = sx(er, w) < sbv; else c = sx(er, w) > sbv;
          end
        endcase
      end
    endcase
    if (ew) er = '0;
    et = ew ? 1'b0 : (c ^ op[0]);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                       input logic [5:0] op);
    logic [63:0] er; logic et, ew; string tag;
    model(a, b, sz, op, er, et, ew, tag);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; size = sz; opcode = op;
    @(posedge clk); #1;
    chk({tag, " R1 valid"}, 64'(out_valid), 64'd1);
    chk({tag, " R2 result"}, out_result, er);
    chk({tag, " taken"}, 64'(out_taken), 64'(et));
    chk({tag, " R11 wrong"}, 64'(out_wrong), 64'(ew));
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] hr; logic ht, hw;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 valid", 64'(out_valid), 0);
    chk("R12 result", out_result, 0);
    chk("R12 taken", 64'(out_taken), 0);
    chk("R12 wrong", 64'(out_wrong), 0);
    @(negedge clk); rst_n = 1'b1;

    // R3 signed vs unsigned at byte boundary: 0x80 is -128 signed, 128 unsigned
    apply(64'h80, 64'h01, 2'd0, 6'b10_001_0);
    apply(64'h80, 64'h01, 2'd0, 6'b10_011_0);
    apply(64'hFF_0080, 64'h1, 2'd1, 6'b10_010_0);
    apply(64'h1234, 64'h5_1234, 2'd1, 6'b10_000_0);
    apply(64'h1234, 64'h5_1234, 2'd1, 6'b10_000_1); // R4 inversion
    // R5 subtract borrow / overflow at 32 and 64 bits
    apply(64'h0, 64'h1, 2'd2, 6'b00_100_0);
    apply(64'h8000_0000, 64'h1, 2'd2, 6'b00_011_0);
    apply(64'h8000_0000_0000_0000, 64'h1, 2'd3, 6'b00_011_0);
    apply(64'h5, 64'h5, 2'd3, 6'b00_000_0);
    apply(64'h5, 64'h3, 2'd0, 6'b00_010_0);
    // R6 add carry / overflow
    apply(64'hFF, 64'h1, 2'd0, 6'b01_100_0);
    apply(64'h7F, 64'h1, 2'd0, 6'b01_011_0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'd3, 6'b01_000_0);
    apply(64'h7FFF, 64'h1, 2'd1, 6'b01_001_0);
    // R7 logical
    apply(64'hF0, 64'h0F, 2'd0, 6'b11_000_0);
    apply(64'hF00, 64'h0F, 2'd0, 6'b11_001_0);
    apply(64'hAB, 64'hAB, 2'd0, 6'b11_010_0);
    // R8 test bit in and out of range
    apply(64'h80, 64'd7, 2'd0, 6'b11_011_0);
    apply(64'hFF, 64'd8, 2'd1, 6'b11_011_0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd40, 2'd2, 6'b11_011_0);
    apply(64'h8000_0000_0000_0000, 64'd63, 2'd3, 6'b11_011_0);
    // R9
    apply(64'hF3, 64'h33, 2'd0, 6'b11_100_0);
    apply(64'hF0, 64'h0F, 2'd0, 6'b11_101_0);
    // R10 increment compare across sign boundary
    apply(64'h7F, 64'h10, 2'd0, 6'b11_110_0);
    apply(64'h7F, 64'h10, 2'd0, 6'b11_111_0);
    apply(64'hFFFF_FFFE, 64'h0, 2'd2, 6'b11_110_0);
    // R11 illegal codes with inversion
    apply(64'h1, 64'h1, 2'd3, 6'b00_101_1);
    apply(64'h1, 64'h1, 2'd3, 6'b01_111_1);
    apply(64'h1, 64'h2, 2'd1, 6'b10_110_1);

    // R1 hold: idle cycle keeps outputs
    hr = out_result; ht = out_taken; hw = out_wrong;
    apply(64'h1234, 64'h0FF, 2'd1, 6'b01_000_0);
    hr = out_result; ht = out_taken; hw = out_wrong;
    @(negedge clk); in_valid = 1'b0; op_a = '1; opcode = 6'b11_001_1;
    @(posedge clk); #1;
    chk("R1 idle valid", 64'(out_valid), 0);
    chk("R1 hold result", out_result, hr);
    chk("R1 hold flags", {62'd0, out_taken, out_wrong}, {62'd0, ht, hw});

    for (int i = 0; i < 2000; i++)
      apply({$urandom, $urandom}, (i % 3 == 0) ? 64'($urandom % 70) : {$urandom, $urandom},
            2'($urandom), 6'($urandom));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule